// File: doc/BRIEF.md
# Transmit-Only Serial Byte Streamer

This block sends the contents of a 128-byte memory out of one serial data pin. It is paced by a separate transmit clock input, and it works only while the mode controller grants transmit-only operation. The transmit clock is treated as asynchronous. It passes through a synchroniser and a rising-edge detector in the system clock domain, so all state is updated on the system clock.

After reset, or each time the mode is entered again, the first nine transmit-clock rising edges only synchronise the block, and the pin stays released. From the tenth edge on, each byte uses nine edges. The first eight drive the data bits, most significant first. The ninth is a don't-care slot with the pin released. On that ninth slot the read address steps to the next byte, and it wraps from the last location back to zero. The block reads the memory through a combinational read port: it drives an address and samples the returned byte when it needs a bit.

The stream runs only while both the mode enable and the bus-clock-high indication are asserted. If either drops, the pin is released at once. When both return, the nine-edge synchronisation starts again at the address that was current when streaming stopped.

Top module: `byte_stream_tx`

## Requirements
- R1: While rst_ni is low and directly after reset, sd_oe_o is 0 and rd_addr_o is 0.
- R2: After reset or after streaming is re-enabled, the first 9 rising edges of tclk_i leave sd_oe_o at 0.
- R3: The 10th rising edge of tclk_i after reset sets sd_oe_o to 1 and sd_o to bit 7 of the byte stored at address 0.
- R4: In each byte, rising edges 1 to 8 drive sd_o with data bits 7 down to 0, in that order, with sd_oe_o at 1.
- R5: Rising edge 9 of each byte (the don't-care slot) sets sd_oe_o to 0.
- R6: rd_addr_o advances by one on the don't-care slot of each byte and wraps from DEPTH-1 (127) to 0.
- R7: When mode_en_i is 0, sd_oe_o is 0 in the same cycle, and tclk_i edges do not change rd_addr_o.
- R8: When bus_clk_hi_i is 0, sd_oe_o is 0 in the same cycle, and tclk_i edges do not change rd_addr_o.
- R9: When streaming is re-enabled, the 9-edge synchronisation runs again while rd_addr_o is kept. The 10th edge then drives bit 7 of the byte at that address.
- R10: Without a new tclk_i rising edge, sd_o and sd_oe_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tclk_i | input | 1 | Asynchronous transmit clock |
| mode_en_i | input | 1 | Transmit-only mode granted by the mode controller |
| bus_clk_hi_i | input | 1 | High while the bidirectional bus clock line is held high |
| rd_addr_o | output | ADDR_W (7) | Memory read address |
| rd_data_i | input | DATA_W (8) | Memory read data for rd_addr_o |
| sd_o | output | 1 | Serial data out value |
| sd_oe_o | output | 1 | Output enable for the data pin; 0 means high impedance |

## Verification
The bench checks the exact edge that drives the first bit. A synchronisation counter that is off by one would drive bit 7 on edge 9 or edge 11, and the bench would see the pin enabled too early or driven too late. It checks the don't-care slot, which a design would miss if it started the next byte at once, and it steps through the whole array to catch a pointer that does not wrap or skips an address. It also drops each enable in the middle of a byte. A design that cleared the pointer would restart at address 0 after re-entry, and one that skipped resynchronisation would drive data before the ninth edge.

// File: rtl/bs_pkg.sv
package bs_pkg;
  typedef enum logic {PH_SYNC, PH_DATA} phase_e;
endpackage

// File: rtl/bs_edge_sync.sv
module bs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/bs_slot_ctrl.sv
module bs_slot_ctrl
  import bs_pkg::*;
#(
  parameter int SYNC_PULSES = 9,
  parameter int DATA_W      = 8,
  localparam int CNT_MAX    = (SYNC_PULSES > DATA_W) ? SYNC_PULSES : DATA_W + 1,
  localparam int CNT_W      = $clog2(CNT_MAX),
  localparam int IDX_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             rise_i,
  output logic             in_sync_o,
  output logic             bit_en_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             byte_done_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step        = rise_i & active_i;
  assign in_sync_o   = (phase_q == PH_SYNC);
  assign bit_en_o    = step & (phase_q == PH_DATA) & (cnt_q < CNT_W'(DATA_W));
  assign byte_done_o = step & (phase_q == PH_DATA) & (cnt_q == CNT_W'(DATA_W));
  assign bit_idx_o   = IDX_W'(DATA_W - 1 - int'(cnt_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (!active_i) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (rise_i) begin
      if (phase_q == PH_SYNC) begin
        if (cnt_q == CNT_W'(SYNC_PULSES - 1)) begin
          phase_q <= PH_DATA;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_q == CNT_W'(DATA_W)) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5: data phase never goes past the don't-care slot
  p_slot_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA) |-> (cnt_q <= CNT_W'(DATA_W)));
endmodule

// File: rtl/bs_addr_ctr.sv
module bs_addr_ctr #(
  parameter int ADDR_W = 7,
  parameter int DEPTH  = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LastAddr = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_o <= '0;
    else if (inc_i) addr_o <= (addr_o == LastAddr) ? '0 : addr_o + 1'b1;
  end
endmodule

// File: rtl/byte_stream_tx.sv
module byte_stream_tx #(
  parameter int ADDR_W      = 7,
  parameter int DEPTH       = 128,
  parameter int DATA_W      = 8,
  parameter int SYNC_PULSES = 9,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tclk_i,
  input  logic              mode_en_i,
  input  logic              bus_clk_hi_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sd_o,
  output logic              sd_oe_o
);
  logic             active, rise, in_sync, bit_en, byte_done;
  logic [IDX_W-1:0] bit_idx;
  logic             sd_q, oe_q;

  assign active = mode_en_i & bus_clk_hi_i;

  bs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(tclk_i), .rise_o(rise)
  );

  bs_slot_ctrl #(.SYNC_PULSES(SYNC_PULSES), .DATA_W(DATA_W)) u_slot (
    .clk_i, .rst_ni, .active_i(active), .rise_i(rise),
    .in_sync_o(in_sync), .bit_en_o(bit_en), .bit_idx_o(bit_idx),
    .byte_done_o(byte_done)
  );

  bs_addr_ctr #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_addr (
    .clk_i, .rst_ni, .inc_i(byte_done), .addr_o(rd_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_q <= 1'b1;
      oe_q <= 1'b0;
    end else if (!active) begin
      oe_q <= 1'b0;
    end else if (bit_en) begin
      sd_q <= rd_data_i[bit_idx];
      oe_q <= 1'b1;
    end else if (byte_done) begin
      oe_q <= 1'b0;
    end
  end

  // exit releases the pin without waiting for a clock edge
  assign sd_o    = sd_q;
  assign sd_oe_o = oe_q & active;

  p_addr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done |=> (rd_addr_o == (($past(rd_addr_o) == ADDR_W'(DEPTH - 1)) ?
                                 '0 : $past(rd_addr_o) + 1'b1)));

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_done |=> $stable(rd_addr_o));

  p_sync_hiz_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sync |-> !sd_oe_o);

  p_reentry_hiz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active) |-> !sd_oe_o);

  p_sd_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en |=> $stable(sd_o));
endmodule

// File: tb/tb_byte_stream_tx.sv
module tb_byte_stream_tx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tclk = 1'b0;
  logic       mode_en = 1'b1;
  logic       bus_hi = 1'b1;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       sd, sd_oe;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_f(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  assign rd_data = mem_f(int'(rd_addr));

  byte_stream_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .tclk_i(tclk), .mode_en_i(mode_en),
    .bus_clk_hi_i(bus_hi), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .sd_o(sd), .sd_oe_o(sd_oe)
  );

  typedef struct packed {
    logic [3:0] pulses;
    logic       oe;
    logic [6:0] addr;
    logic [2:0] bidx;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{4'd9, 1'b0, 7'd0, 3'd0},
    '{4'd1, 1'b1, 7'd0, 3'd7},
    '{4'd1, 1'b1, 7'd0, 3'd6},
    '{4'd6, 1'b1, 7'd0, 3'd0},
    '{4'd1, 1'b0, 7'd1, 3'd0},
    '{4'd1, 1'b1, 7'd1, 3'd7},
    '{4'd8, 1'b0, 7'd2, 3'd0},
    '{4'd4, 1'b1, 7'd2, 3'd4}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tclk = 1'b1;
      repeat (8) @(posedge clk);
      #1 tclk = 1'b0;
      repeat (8) @(posedge clk);
      #2;
    end
  endtask

  task automatic check_byte(input int a);
    for (int b = 7; b >= 0; b--) begin
      pulse(1);
      chk(sd_oe == 1'b1, "R4 oe during data bit", int'(sd_oe), 1);
      chk(sd == mem_f(a)[b], "R4 data bit", int'(sd), int'(mem_f(a)[b]));
    end
    pulse(1);
    chk(sd_oe == 1'b0, "R5 dont-care slot oe", int'(sd_oe), 0);
    chk(int'(rd_addr) == ((a + 1) % 128), "R6 address step", int'(rd_addr), (a + 1) % 128);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic hold_sd, hold_oe;
    #1;
    chk(sd_oe == 1'b0, "R1 oe in reset", int'(sd_oe), 0);
    chk(rd_addr == 7'd0, "R1 addr in reset", int'(rd_addr), 0);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    chk(sd_oe == 1'b0, "R1 oe after reset", int'(sd_oe), 0);

    // R2, R3, R4, R5, R6 startup sequence
    foreach (VEC[i]) begin
      pulse(int'(VEC[i].pulses));
      chk(sd_oe == VEC[i].oe, $sformatf("R3 vec%0d oe", i), int'(sd_oe), int'(VEC[i].oe));
      chk(rd_addr == VEC[i].addr, $sformatf("R6 vec%0d addr", i), int'(rd_addr), int'(VEC[i].addr));
      if (VEC[i].oe)
        chk(sd == mem_f(int'(VEC[i].addr))[VEC[i].bidx], $sformatf("R4 vec%0d bit", i),
            int'(sd), int'(mem_f(int'(VEC[i].addr))[VEC[i].bidx]));
    end

    // R10: outputs hold with no transmit-clock edge
    hold_sd = sd; hold_oe = sd_oe;
    repeat (40) @(posedge clk);
    #2;
    chk(sd == hold_sd && sd_oe == hold_oe, "R10 hold without edge",
        int'({sd, sd_oe}), int'({hold_sd, hold_oe}));

    // R7: mode exit mid-byte
    @(posedge clk); #1 mode_en = 1'b0;
    #1 chk(sd_oe == 1'b0, "R7 immediate release", int'(sd_oe), 0);
    pulse(3);
    chk(sd_oe == 1'b0, "R7 edges ignored oe", int'(sd_oe), 0);
    chk(rd_addr == 7'd2, "R7 edges ignored addr", int'(rd_addr), 2);

    // R9: re-entry resynchronises and keeps address
    @(posedge clk); #1 mode_en = 1'b1;
    pulse(9);
    chk(sd_oe == 1'b0, "R9 resync 9 edges", int'(sd_oe), 0);
    chk(rd_addr == 7'd2, "R9 address kept", int'(rd_addr), 2);
    pulse(1);
    chk(sd_oe == 1'b1, "R9 tenth edge oe", int'(sd_oe), 1);
    chk(sd == mem_f(2)[7], "R9 restart at MSB", int'(sd), int'(mem_f(2)[7]));

    // R8: bus clock low acts as exit
    @(posedge clk); #1 bus_hi = 1'b0;
    #1 chk(sd_oe == 1'b0, "R8 immediate release", int'(sd_oe), 0);
    pulse(2);
    chk(rd_addr == 7'd2, "R8 edges ignored addr", int'(rd_addr), 2);
    @(posedge clk); #1 bus_hi = 1'b1;
    pulse(9);
    chk(sd_oe == 1'b0, "R8 R2 resync after bus high", int'(sd_oe), 0);

    // R6: full pass with wrap
    for (int a = 2; a < 128; a++) check_byte(a);
    check_byte(0);
    chk(rd_addr == 7'd1, "R6 after wrap", int'(rd_addr), 1);

    // R1: reset mid-stream
    pulse(3);
    #1 rst_ni = 1'b0;
    #1;
    chk(sd_oe == 1'b0, "R1 oe on reset", int'(sd_oe), 0);
    chk(rd_addr == 7'd0, "R1 addr on reset", int'(rd_addr), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule